// File: doc/BRIEF.md
# Register-Indirect Memory Read Sequencer

This block fetches one word from an external memory on behalf of a single-bus processor core. A start request carries a source address and the index of a destination register. The block loads the address into its address register and raises the read command in that same control step. The address register drives the memory address lines at all times, so the new address and the read command appear together on the cycle after the request.

The block then waits for the memory to raise its completion flag. This can take any number of cycles, and there is no timeout. While it waits, the data register keeps loading from the memory data lines, so the word present in the cycle the flag is sampled high is the one kept. The read command drops after that cycle.

In the next cycle the data register drives the internal bus and a one-cycle done strobe marks that the destination register is written. The destination index appears on a select output during that cycle. A start request made while a read is in progress has no effect.

Top module: `mem_read_seq`

## Requirements
- R1: During and directly after reset, mem_rd is 0, done is 0, ibus is 0 and mem_addr is 0.
- R2: A start sampled high while idle causes mem_addr to equal src_addr and mem_rd to be 1 on the next cycle, both in the same cycle.
- R3: While mem_rd is 1 and mfc is sampled low, mem_rd stays 1 on the next cycle, however long mfc stays low.
- R4: In the cycle after mfc is sampled high with mem_rd at 1, mem_rd is 0 and done is 1.
- R5: In the done cycle, ibus equals the mem_data value sampled together with mfc high, and wr_sel equals the dst_sel value given with the accepted start.
- R6: done is high for exactly one cycle per read, and ibus is 0 in every cycle in which done is 0.
- R7: A start raised while mem_rd is 1, or during the done cycle, is ignored: mem_addr, wr_sel and the read sequence are unchanged.
- R8: mem_addr keeps the last accepted address after the read completes, until the next accepted start.
- R9: mfc raised while no read is pending has no effect: mem_rd and done stay 0.
- R10: Values on mem_data in wait cycles where mfc is low do not reach ibus.
- R11: A start in the cycle directly after the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Read request |
| src_addr | input | AW | Memory address to read |
| dst_sel | input | SW | Destination register index |
| mem_data | input | DW | Memory bus data lines |
| mfc | input | 1 | Memory function complete flag |
| mem_addr | output | AW | Memory bus address lines |
| mem_rd | output | 1 | Read command on memory bus |
| ibus | output | DW | Internal bus value, 0 when not driven |
| wr_sel | output | SW | Destination index, valid while done |
| done | output | 1 | One-cycle destination-write strobe |

## Verification
The assertions check the handshake on every cycle. The read command holds until the completion flag and then drops with done rising. done never lasts two cycles. The bus carries the data word captured with the flag. The address is stable while a read is pending. Only the bench scenarios show the rest: that each read reaches the right destination index, that junk on the data lines before completion is discarded, that starts made mid-read are dropped, and that a back-to-back request is taken in the first idle cycle. The bench covers latencies from zero to several wait cycles.

// File: rtl/mem_read_seq.sv
module mem_read_seq #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int SW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_addr,
  input  logic [SW-1:0] dst_sel,
  input  logic [DW-1:0] mem_data,
  input  logic          mfc,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic [DW-1:0] ibus,
  output logic [SW-1:0] wr_sel,
  output logic          done
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_PUT} st_t;

  st_t           st;
  logic [AW-1:0] mar;
  logic [DW-1:0] mdr;
  logic [SW-1:0] dst_q;
  logic          rd_q;

  wire mar_ld      = (st == S_IDLE) && start;
  wire mdr_ld_mem  = (st == S_WAIT);
  wire mdr_drv_bus = (st == S_PUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      mar   <= '0;
      mdr   <= '0;
      dst_q <= '0;
      rd_q  <= 1'b0;
    end else begin
      if (mar_ld) begin
        mar   <= src_addr;
        dst_q <= dst_sel;
        rd_q  <= 1'b1;
      end
      if (mdr_ld_mem) mdr <= mem_data;
      case (st)
        S_IDLE: if (start) st <= S_WAIT;
        S_WAIT: if (mfc) begin
          st   <= S_PUT;
          rd_q <= 1'b0;
        end
        S_PUT:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_addr = mar;
  assign mem_rd   = rd_q;
  assign ibus     = mdr_drv_bus ? mdr : '0;
  assign done     = mdr_drv_bus;
  assign wr_sel   = dst_q;

  AST_RD_HOLDS:    assert property (@(posedge clk) disable iff (!rst_n) mem_rd && !mfc |=> mem_rd); // R3
  AST_RD_RELEASE:  assert property (@(posedge clk) disable iff (!rst_n) mem_rd && mfc |=> !mem_rd && done); // R4
  AST_BUS_DATA:    assert property (@(posedge clk) disable iff (!rst_n) mem_rd && mfc |=> ibus == $past(mem_data)); // R5
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_BUS_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !done |-> ibus == '0); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) mem_rd && $past(mem_rd) |-> $stable(mem_addr)); // R7
  AST_IDLE_MFC:    assert property (@(posedge clk) disable iff (!rst_n) !mem_rd && !done && !start |=> !mem_rd && !done); // R9

endmodule

// File: tb/test_mem_read_seq.sv
module test_mem_read_seq;
  localparam int AW = 16, DW = 16, NREG = 8, SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] src_addr = '0;
  logic [SW-1:0] dst_sel = '0;
  logic [DW-1:0] mem_data = '0;
  logic          mfc = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic [DW-1:0] ibus;
  logic [SW-1:0] wr_sel;
  logic          done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  mem_read_seq #(.AW(AW), .DW(DW), .NREG(NREG)) i_mem_read_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
    .dst_sel(dst_sel), .mem_data(mem_data), .mfc(mfc), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .ibus(ibus), .wr_sel(wr_sel), .done(done)
  );

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] exp_bus(input logic strobe, input logic [DW-1:0] word);
    return strobe ? word : '0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Caller is at a negedge with the block idle.
  task automatic do_read(input logic [AW-1:0] a, input logic [SW-1:0] d,
                         input int lat, input logic [DW-1:0] word, input bit noisy);
    start = 1'b1; src_addr = a; dst_sel = d; mfc = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R2 addr", 32'(mem_addr), 32'(a));
    chk("R2 rd", 32'(mem_rd), 32'd1);
    start = noisy; src_addr = ~a; dst_sel = ~d;
    for (int i = 0; i < lat; i++) begin
      mfc = 1'b0; mem_data = DW'($urandom);
      @(posedge clk); @(negedge clk);
      chk("R3 rd held", 32'(mem_rd), 32'd1);
      chk("R7 addr kept", 32'(mem_addr), 32'(a));
      chk("R6 bus quiet", 32'(ibus), 32'd0);
    end
    mfc = 1'b1; mem_data = word;
    @(posedge clk); @(negedge clk);
    chk("R4 rd low", 32'(mem_rd), 32'd0);
    chk("R4 done", 32'(done), 32'd1);
    chk("R5 R10 bus", 32'(ibus), 32'(exp_bus(1'b1, word)));
    chk("R5 R7 wr_sel", 32'(wr_sel), 32'(d));
    mfc = 1'b0; mem_data = DW'($urandom);
    @(posedge clk); @(negedge clk);
    chk("R6 done pulse", 32'(done), 32'd0);
    chk("R6 bus quiet", 32'(ibus), 32'(exp_bus(1'b0, word)));
    chk("R7 no restart", 32'(mem_rd), 32'd0);
    chk("R8 addr held", 32'(mem_addr), 32'(a));
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rd", 32'(mem_rd), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 bus", 32'(ibus), 32'd0);
    chk("R1 addr", 32'(mem_addr), 32'd0);
    rst_n = 1'b1;
    mfc = 1'b1; mem_data = 16'hBEEF;
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      chk("R9 rd", 32'(mem_rd), 32'd0);
      chk("R9 done", 32'(done), 32'd0);
    end
    mfc = 1'b0;
    do_read(16'h1234, 3'd5, 0, 16'hA5A5, 1'b0);
    do_read(16'hFFFF, 3'd7, 9, 16'h0001, 1'b1);
    do_read(16'h0000, 3'd0, 1, 16'hFFFF, 1'b1);   // R11 back-to-back
    repeat (4) @(negedge clk);
    chk("R8 idle addr", 32'(mem_addr), 32'h0000);
    for (int n = 0; n < 60; n++)
      do_read(AW'($urandom), SW'($urandom), int'($urandom_range(0, 6)),
              DW'($urandom), 1'($urandom));
    summary();
  end
endmodule